// File: doc/BRIEF.md
# Late-write synchronous burst SRAM

This block is a synthesizable behavioural model of a synchronous static RAM in which write data trails its write command by the same number of clock edges as read data trails a read command. A controller can therefore issue reads and writes in any mix, one per cycle, and the shared data bus never needs an idle turnaround cycle. Commands are loaded with an explicit address or advanced as burst beats from an internal two-bit counter. A clock enable freezes the whole pipeline, and three chip selects decode a deselect that still lets earlier transfers drain.

Two latencies are supported through a static mode pin. In pipelined mode read data comes from an output register and write data is sampled two edges after the command. In flow-through mode read data comes straight from the array and write data is sampled one edge after the command. A small array stands in for the full depth. A snooze input blocks new commands and keeps the bus quiet while the stored contents are kept.

Top module: `latewr_sram`

## Requirements
- R1: On an accepted edge (clk_en_n low, snooze low) with burst_adv low, the device is selected only when chip_sel_a_n is low, chip_sel_b is high and chip_sel_c_n is low. When selected, rd_wr_n high starts a read and rd_wr_n low starts a write at addr. Any other chip-select combination issues an idle slot.
- R2: In pipelined mode (flow_thru_n high), data for a read issued at edge k is driven during the cycle between edges k+1 and k+2.
- R3: In flow-through mode (flow_thru_n low), data for a read issued at edge k is driven during the cycle between edges k and k+1.
- R4: Write data on d_in is sampled at edge k+2 in pipelined mode and at edge k+1 in flow-through mode. Reads and writes may alternate on consecutive edges with no idle cycle.
- R5: byte_wr_n bit i low enables byte i, which is d_in bits 8i+7 down to 8i. The enables are sampled with the command or beat, and only enabled bytes of the word change.
- R6: With burst_adv high, addr, rd_wr_n and the chip selects are ignored. The previous operation type repeats at the next beat address: the upper address bits are kept and the low two bits are the start value XOR the beat count modulo 4. After an idle slot, an advance stays idle.
- R7: With clk_en_n high, an edge changes no internal state: no command, pipeline, burst count, output register or array update.
- R8: After a deselect, transfers still pending from earlier commands complete in the following cycles, and the bus is not driven for idle slots.
- R9: d_oe is high only when out_en_n is low and the current data slot belongs to a read. out_en_n takes effect without a clock and is not needed for writes.
- R10: A read whose data slot falls right after a pending write to the same word returns the newly written bytes merged with the old unwritten bytes.
- R11: While snooze is high, accepted edges issue idle slots, bursts end, d_oe stays low, and the array contents are retained.
- R12: While reset is applied and right after it, no operation is pending and d_oe is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| clk_en_n | input | 1 | Clock enable, active low; high stalls everything |
| chip_sel_a_n | input | 1 | Chip select, active low |
| chip_sel_b | input | 1 | Chip select, active high |
| chip_sel_c_n | input | 1 | Chip select, active low |
| burst_adv | input | 1 | High advances the burst, low loads a new command |
| rd_wr_n | input | 1 | High read, low write (on load) |
| addr | input | AW | Word address |
| byte_wr_n | input | DW/8 | Byte write enables, active low |
| flow_thru_n | input | 1 | Low selects flow-through latency, high pipelined (static) |
| out_en_n | input | 1 | Asynchronous output enable, active low |
| snooze | input | 1 | Low-power request; blocks new commands |
| d_in | input | DW | Write data from the bus |
| d_out | output | DW | Read data to the bus |
| d_oe | output | 1 | Bus drive enable for d_out |

## Verification
The assertions take flow_thru_n as static outside reset and treat all synchronous inputs as stable around the rising edge. The bench changes inputs two nanoseconds after each edge and compares outputs on the falling edge. It changes the latency mode only while reset is held. Before it reads any word, it writes every location once with all bytes enabled, so no comparison depends on uninitialised contents.

// File: rtl/latewr_sram.sv
module latewr_sram #(
  parameter int AW        = 8,
  parameter int DW        = 16,
  parameter int BYTE_W    = 8,
  parameter int BURST_XOR = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clk_en_n,
  input  logic              chip_sel_a_n,
  input  logic              chip_sel_b,
  input  logic              chip_sel_c_n,
  input  logic              burst_adv,
  input  logic              rd_wr_n,
  input  logic [AW-1:0]     addr,
  input  logic [DW/8-1:0]   byte_wr_n,
  input  logic              flow_thru_n,
  input  logic              out_en_n,
  input  logic              snooze,
  input  logic [DW-1:0]     d_in,
  output logic [DW-1:0]     d_out,
  output logic              d_oe
);
  localparam int NB    = DW / BYTE_W;
  localparam int DEPTH = 1 << AW;

  typedef enum logic [1:0] {OP_IDLE = 2'd0, OP_RD = 2'd1, OP_WR = 2'd2} op_t;

  op_t             s1_op, s2_op, n_op, d_op;
  logic [AW-1:0]   s1_addr, s2_addr, n_addr, d_addr;
  logic [NB-1:0]   s1_be, s2_be, d_be;
  logic [1:0]      b_start, b_cnt, nxt_cnt, nxt_lo;
  logic [DW-1:0]   mem [DEPTH];
  logic [DW-1:0]   rd_q, fwd;

  wire picked = !chip_sel_a_n && chip_sel_b && !chip_sel_c_n;
  wire pipe   = flow_thru_n;

  assign nxt_cnt = b_cnt + 2'd1;
  assign nxt_lo  = (BURST_XOR != 0) ? (b_start ^ nxt_cnt) : (b_start + nxt_cnt);

  always_comb begin
    n_op   = OP_IDLE;
    n_addr = addr;
    if (!snooze) begin
      if (!burst_adv) begin
        if (picked) n_op = rd_wr_n ? OP_RD : OP_WR;
      end else begin
        n_op   = s1_op;
        n_addr = {s1_addr[AW-1:2], nxt_lo};
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_op   <= OP_IDLE;
      s2_op   <= OP_IDLE;
      s1_addr <= '0;
      s2_addr <= '0;
      s1_be   <= '0;
      s2_be   <= '0;
      b_start <= 2'd0;
      b_cnt   <= 2'd0;
      rd_q    <= '0;
    end else if (!clk_en_n) begin
      s1_op   <= n_op;
      s1_addr <= n_addr;
      s1_be   <= ~byte_wr_n;
      s2_op   <= s1_op;
      s2_addr <= s1_addr;
      s2_be   <= s1_be;
      rd_q    <= fwd;
      if (!burst_adv) begin
        b_start <= addr[1:0];
        b_cnt   <= 2'd0;
      end else begin
        b_cnt   <= nxt_cnt;
      end
    end
  end

  // data stage: where write data is taken and read data is shown
  assign d_op   = pipe ? s2_op   : s1_op;
  assign d_addr = pipe ? s2_addr : s1_addr;
  assign d_be   = pipe ? s2_be   : s1_be;

  always_ff @(posedge clk) begin
    if (rst_n && !clk_en_n && d_op == OP_WR) begin
      for (int b = 0; b < NB; b++)
        if (d_be[b]) mem[d_addr][b*BYTE_W +: BYTE_W] <= d_in[b*BYTE_W +: BYTE_W];
    end
  end

  // newest data for a pipelined read fetched at the edge its predecessor write lands
  always_comb begin
    fwd = mem[s1_addr];
    if (s2_op == OP_WR && s2_addr == s1_addr)
      for (int b = 0; b < NB; b++)
        if (s2_be[b]) fwd[b*BYTE_W +: BYTE_W] = d_in[b*BYTE_W +: BYTE_W];
  end

  assign d_out = pipe ? rd_q : mem[s1_addr];
  assign d_oe  = !out_en_n && !snooze && (d_op == OP_RD);

  a_r1_load_decode: assert property (@(posedge clk) disable iff (!rst_n)
    (!clk_en_n && !snooze && !burst_adv && picked) |=>
      (s1_op == ($past(rd_wr_n) ? OP_RD : OP_WR)) && (s1_addr == $past(addr)));

  a_r1_deselect_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (!clk_en_n && !burst_adv && !picked) |=> (s1_op == OP_IDLE));

  a_r6_burst_keeps_page: assert property (@(posedge clk) disable iff (!rst_n)
    (!clk_en_n && !snooze && burst_adv) |=>
      (s1_op == $past(s1_op)) && (s1_addr[AW-1:2] == $past(s1_addr[AW-1:2])));

  a_r7_stall_freezes: assert property (@(posedge clk) disable iff (!rst_n)
    clk_en_n |=> ($stable(s1_op) && $stable(s1_addr) && $stable(s2_op) &&
                  $stable(b_cnt) && $stable(rd_q)));

  a_r8_pending_drains: assert property (@(posedge clk) disable iff (!rst_n)
    (!clk_en_n && s1_op != OP_IDLE) |=> (s2_op == $past(s1_op)));

  a_r11_snooze_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    (!clk_en_n && snooze) |=> (s1_op == OP_IDLE));
endmodule

// File: tb/latewr_sram_tb_top.sv
`timescale 1ns/1ps
module latewr_sram_tb_top;
  localparam int AW = 8;
  localparam int DW = 16;
  localparam int NB = DW / 8;
  localparam int DEPTH = 1 << AW;

  logic clk = 1'b0, rst_n = 1'b0, clk_en_n = 1'b0;
  logic chip_sel_a_n = 1'b1, chip_sel_b = 1'b1, chip_sel_c_n = 1'b0;
  logic burst_adv = 1'b0, rd_wr_n = 1'b1, flow_thru_n = 1'b1;
  logic out_en_n = 1'b0, snooze = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [NB-1:0] byte_wr_n = '0;
  logic [DW-1:0] d_in = '0;
  logic [DW-1:0] d_out;
  logic d_oe;

  latewr_sram #(.AW(AW), .DW(DW)) dut_i (
    .clk(clk), .rst_n(rst_n), .clk_en_n(clk_en_n),
    .chip_sel_a_n(chip_sel_a_n), .chip_sel_b(chip_sel_b), .chip_sel_c_n(chip_sel_c_n),
    .burst_adv(burst_adv), .rd_wr_n(rd_wr_n), .addr(addr), .byte_wr_n(byte_wr_n),
    .flow_thru_n(flow_thru_n), .out_en_n(out_en_n), .snooze(snooze),
    .d_in(d_in), .d_out(d_out), .d_oe(d_oe));

  always #5 clk = ~clk;

  int nchk = 0, nfail = 0;
  string cur_req = "R12";
  bit done = 0;

  // behavioural reference: slot 1 = due at next edge, slot 2 = due in two edges
  logic [DW-1:0] mm [DEPTH];
  int sop [1:2];
  int saddr [1:2];
  logic [NB-1:0] sbe [1:2];
  int bop = 0, bstart = 0, bcnt = 0;
  bit exp_v = 0;
  logic [DW-1:0] exp_d = '0;

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 1; i <= 2; i++) begin sop[i] = 0; saddr[i] = 0; sbe[i] = '0; end
      bop = 0; exp_v = 0;
    end else if (!clk_en_n) begin
      int op, a, lat;
      if (sop[1] == 2)
        for (int b = 0; b < NB; b++)
          if (sbe[1][b]) mm[saddr[1]][b*8 +: 8] = d_in[b*8 +: 8];
      sop[1] = sop[2]; saddr[1] = saddr[2]; sbe[1] = sbe[2];
      sop[2] = 0; saddr[2] = 0; sbe[2] = '0;
      op = 0; a = 0;
      if (!snooze) begin
        if (!burst_adv) begin
          if (!chip_sel_a_n && chip_sel_b && !chip_sel_c_n) begin
            op = rd_wr_n ? 1 : 2; a = int'(addr);
            bstart = a; bcnt = 0; bop = op;
          end else bop = 0;
        end else if (bop != 0) begin
          bcnt = (bcnt + 1) % 4;
          a = (bstart & ~3) | ((bstart & 3) ^ bcnt);
          op = bop;
        end
      end else bop = 0;
      lat = flow_thru_n ? 2 : 1;
      sop[lat] = op; saddr[lat] = a; sbe[lat] = ~byte_wr_n;
      exp_v = (sop[1] == 1);
      exp_d = mm[saddr[1]];
    end
  end

  always @(negedge clk) begin
    if (!done) begin
      bit eoe;
      eoe = exp_v && !out_en_n && !snooze;
      nchk++;
      if (d_oe !== eoe) begin
        nfail++;
        $display("FAIL %s: d_oe=%0b expected %0b at %0t", cur_req, d_oe, eoe, $time);
      end else if (eoe && d_out !== exp_d) begin
        nfail++;
        $display("FAIL %s: d_out=%h expected %h at %0t", cur_req, d_out, exp_d, $time);
      end
    end
  end

  always @(posedge clk) #2 d_in <= DW'($urandom);

  task automatic step(); @(posedge clk); #2; endtask

  task automatic sel_ok(); chip_sel_a_n = 0; chip_sel_b = 1; chip_sel_c_n = 0; endtask

  task automatic cmd(input bit rd, input int a, input logic [NB-1:0] bwn);
    clk_en_n = 0; burst_adv = 0; sel_ok(); rd_wr_n = rd; addr = AW'(a); byte_wr_n = bwn; step();
  endtask

  task automatic adv(input logic [NB-1:0] bwn);
    clk_en_n = 0; burst_adv = 1; addr = AW'($urandom); rd_wr_n = 1'($urandom);
    chip_sel_a_n = 1'($urandom); chip_sel_b = 1'($urandom); chip_sel_c_n = 1'($urandom);
    byte_wr_n = bwn; step();
  endtask

  task automatic desel(input int kind);
    clk_en_n = 0; burst_adv = 0; sel_ok(); rd_wr_n = 1'($urandom); addr = AW'($urandom);
    case (kind % 3)
      0: chip_sel_a_n = 1;
      1: chip_sel_b = 0;
      default: chip_sel_c_n = 1;
    endcase
    step();
  endtask

  task automatic stall();
    clk_en_n = 1; burst_adv = 1'($urandom); rd_wr_n = 1'($urandom); addr = AW'($urandom); step();
    clk_en_n = 0;
  endtask

  task automatic rnd_cycle();
    clk_en_n  = ($urandom % 8 == 0);
    out_en_n  = ($urandom % 8 == 0);
    snooze    = ($urandom % 16 == 0);
    burst_adv = ($urandom % 3 == 0);
    rd_wr_n   = 1'($urandom);
    addr      = AW'($urandom % 16);
    byte_wr_n = NB'($urandom);
    sel_ok();
    if ($urandom % 6 == 0) begin
      chip_sel_a_n = 1'($urandom); chip_sel_b = 1'($urandom); chip_sel_c_n = 1'($urandom);
    end
    step();
  endtask

  task automatic directed();
    cur_req = "R4";
    for (int i = 0; i < 16; i++) begin cmd(0, i + 32, '0); cmd(1, i, '0); end
    cur_req = "R2";
    for (int i = 0; i < 16; i++) cmd(1, i + 32, '0);
    cur_req = "R10";
    cmd(0, 5, '0); cmd(1, 5, '0);
    cmd(0, 6, 2'b01); cmd(1, 6, '0);
    cmd(0, 7, '0); desel(0); cmd(1, 7, '0);
    cur_req = "R5";
    cmd(0, 8, 2'b10); cmd(0, 9, 2'b01); cmd(0, 10, 2'b11);
    cmd(1, 8, '0); cmd(1, 9, '0); cmd(1, 10, '0);
    cur_req = "R6";
    cmd(0, 18, '0); adv('0); adv(2'b01); adv('0); adv(2'b10);
    cmd(1, 18, '0); adv('0); adv('0); adv('0); adv('0);
    cmd(1, 45, '0); adv('0); adv('0);
    desel(1); adv('0); adv('0);
    cur_req = "R7";
    cmd(1, 1, '0); stall(); stall(); cmd(0, 2, '0); stall(); adv('0); stall();
    cmd(1, 2, '0); stall(); adv('0); desel(2); stall(); desel(2);
    cur_req = "R8";
    cmd(0, 3, '0); cmd(1, 4, '0); desel(0); desel(1); desel(2); cmd(1, 3, '0); desel(0); desel(0);
    cur_req = "R1";
    for (int k = 0; k < 6; k++) begin desel(k); cmd(1, k + 11, '0); end
    cur_req = "R9";
    out_en_n = 1; cmd(1, 3, '0); cmd(0, 12, '0); cmd(1, 12, '0);
    out_en_n = 0; cmd(1, 12, '0); desel(0); desel(0);
    cur_req = "R11";
    cmd(0, 14, '0); snooze = 1; cmd(0, 14, '0); cmd(1, 14, '0); adv('0); cmd(0, 13, '0);
    snooze = 0; desel(0); desel(0); cmd(1, 14, '0); cmd(1, 13, '0); desel(0); desel(0);
  endtask

  initial begin
    #2;
    repeat (3) step();
    rst_n = 1;
    cur_req = "R12";
    desel(0); desel(0);
    cur_req = "R4";
    for (int i = 0; i < DEPTH; i++) cmd(0, i, '0);
    desel(0); desel(0);
    directed();
    cur_req = "R2";
    repeat (3000) rnd_cycle();
    clk_en_n = 0; snooze = 0; out_en_n = 0;
    rst_n = 0; flow_thru_n = 0; cur_req = "R12";
    repeat (3) step();
    rst_n = 1; desel(0); desel(0);
    cur_req = "R3";
    for (int i = 0; i < 16; i++) begin cmd(0, i + 64, 2'b00); cmd(1, i + 64, '0); end
    directed();
    cur_req = "R3";
    repeat (3000) rnd_cycle();
    clk_en_n = 0; snooze = 0; desel(0); desel(0);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

  initial begin
    #2_000_000;
    if (!done) begin
      done = 1;
      nfail++;
      $display("FAIL watchdog: run did not complete, actual hung expected done");
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
    end
  end
endmodule